// File: doc/BRIEF.md
# Lookup Table Search Engine

This block searches a forwarding table held in a synchronous single-port memory. A command names one search criterion, a 48-bit MAC address and a 12-bit VLAN ID. The engine reads the table one entry per cycle, always starting at index 0 and moving upward. It stops at the first entry that meets the criterion and reports whether a hit was found and at which index.

Four criteria are supported:
- a unicast/multicast address entry with the given VLAN ID and address;
- a VLAN entry with the given VLAN ID;
- the first unused entry;
- the first entry that may be evicted.

A fifth command chooses the slot for an insert. In a single pass it looks for an existing entry for the same address and VLAN. If there is none, it returns the first unused slot. If there is no unused slot, it returns the first evictable slot. If none of these exists, it reports that the table is full.

Entries are 64 bits. Only the fields named in the requirements are interpreted. Writing entries back to the table is left to the surrounding logic.

Top module: `lut_search_engine`

## Requirements
- R1: During and after a synchronous active-low reset, `busy`, `done`, `found` and `tbl_rd_en` are low and `index` is 0.
- R2: A command is taken on a clock edge where `cmd_valid` is high and `busy` is low, and `busy` rises. While `busy` is high, `cmd_valid` and the command fields are ignored: the running search's result is unchanged and no second search follows. `cmd_op` codes are 0 = address search, 1 = VLAN search, 2 = free search, 3 = evictable search and 4 = insert slot. Codes 5 to 7 scan the whole table and report not-found.
- R3: Reads start at index 0 in the cycle after the command is taken and advance by one index each cycle. No more than one read beyond the index that gave the hit is issued. No read is issued while idle.
- R4: `done` is a one-cycle pulse. For a hit at index k it is high in cycle k+2 after the command is taken. With no early stop it is high in cycle DEPTH+1. `busy` falls on the same edge that raises `done`.
- R5: Entry fields are as follows. Bits 61:60 hold the type (0 free, 1 address, 2 VLAN, 3 VLAN plus address). Bits 59:48 hold the VLAN ID. Bits 47:0 hold the MAC address, with its first byte in 47:40. An address search hits an entry whose type is 1 or 3, whose VLAN ID is equal and whose 48 address bits are all equal.
- R6: A VLAN search hits an entry of type 2 with an equal VLAN ID. Other types are skipped even when their VLAN ID is equal.
- R7: A free search hits the first entry of type 0.
- R8: An entry is evictable when its type is 1 or 3, bit 40 (multicast) is clear, and bits 63:62 are neither 0 (persistent) nor 2 (vendor-prefix).
- R9: An insert returns the first address-search hit if there is one. Otherwise it returns the lowest free index. Otherwise it returns the lowest evictable index. An insert with an address hit stops early, as in R4.
- R10: When nothing qualifies, including an insert into a table with no match, no free entry and no evictable entry, `done` comes with `found` low and `index` 0. `found` and `index` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command request, taken only while idle |
| cmd_op | input | 3 | Search criterion code |
| cmd_mac | input | 48 | MAC address key |
| cmd_vid | input | 12 | VLAN ID key |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | The last search produced an index |
| index | output | log2(DEPTH) | Index produced by the last search |
| tbl_rd_en | output | 1 | Table read request |
| tbl_rd_addr | output | log2(DEPTH) | Table read index |
| tbl_rd_data | input | 64 | Entry returned one cycle after the read |

## Verification
The assertions assume that the table returns the addressed entry exactly one cycle after a read. They also assume that the table contents do not change while a search is in progress, so the first hit is well defined. The stimulus modifies the table only between commands, and it drives the read data from a bench memory with one cycle of latency. Commands sent while busy are placed inside long scans, so that an ignored request would be visible both in the result and in the cycles after `done`.

// File: rtl/lse_pkg.sv
// Shared definitions for the lookup table search engine.
// Holds command codes, entry type codes, entry field positions and the
// per-entry classification record.
package lse_pkg;
    localparam int MAC_W     = 48;
    localparam int VID_W     = 12;
    localparam int ENTRY_W   = 64;
    localparam int TYPE_LSB  = 60;
    localparam int VID_LSB   = 48;
    localparam int UC_LSB    = 62;
    localparam int MCAST_BIT = 40;

    typedef enum logic [2:0] {
        OP_ADDR   = 3'd0,
        OP_VLAN   = 3'd1,
        OP_FREE   = 3'd2,
        OP_AGE    = 3'd3,
        OP_INSERT = 3'd4
    } lse_op_e;

    typedef enum logic [1:0] {
        ET_FREE      = 2'd0,
        ET_ADDR      = 2'd1,
        ET_VLAN      = 2'd2,
        ET_VLAN_ADDR = 2'd3
    } lse_etype_e;

    localparam logic [1:0] UC_PERSIST = 2'd0;
    localparam logic [1:0] UC_PREFIX  = 2'd2;

    typedef struct packed {
        logic addr_hit;
        logic vlan_hit;
        logic is_free;
        logic evictable;
    } lse_class_t;
endpackage

// File: rtl/lse_entry_classify.sv
// Combinational classifier for one table entry.
// Compares the entry against the search key and flags each criterion.
// Assumes the entry layout defined in lse_pkg.
module lse_entry_classify
    import lse_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic [MAC_W-1:0]   key_mac,
    input  logic [VID_W-1:0]   key_vid,
    output lse_class_t         cls
);
    logic [1:0]       etype;
    logic [1:0]       uc_kind;
    logic [VID_W-1:0] e_vid;
    logic [MAC_W-1:0] e_mac;
    logic             is_addr_type;

    // Split the entry into fields and evaluate each criterion.
    always_comb begin
        etype        = entry[TYPE_LSB +: 2];
        uc_kind      = entry[UC_LSB +: 2];
        e_vid        = entry[VID_LSB +: VID_W];
        e_mac        = entry[MAC_W-1:0];
        is_addr_type = (etype == ET_ADDR) || (etype == ET_VLAN_ADDR);

        cls.addr_hit  = is_addr_type && (e_vid == key_vid) && (e_mac == key_mac);
        cls.vlan_hit  = (etype == ET_VLAN) && (e_vid == key_vid);
        cls.is_free   = (etype == ET_FREE);
        cls.evictable = is_addr_type && !entry[MCAST_BIT]
                        && (uc_kind != UC_PERSIST) && (uc_kind != UC_PREFIX);
    end
endmodule

// File: rtl/lse_read_seq.sv
// Read sequencer: issues one table read per cycle from index 0 upward.
// It tracks which index the returned data belongs to, given one cycle of
// read latency. Assumes start and stop are never high together.
module lse_read_seq #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_addr,
    output logic             chk_vld,
    output logic [IDX_W-1:0] chk_idx,
    output logic             chk_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic             issuing;
    logic [IDX_W-1:0] iss_idx;

    // Advance the issue pointer and pipeline it to the check stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing <= 1'b0;
            iss_idx <= '0;
            chk_vld <= 1'b0;
            chk_idx <= '0;
        end else if (start) begin
            issuing <= 1'b1;
            iss_idx <= '0;
            chk_vld <= 1'b0;
        end else if (stop) begin
            issuing <= 1'b0;
            chk_vld <= 1'b0;
        end else if (issuing) begin
            chk_vld <= 1'b1;
            chk_idx <= iss_idx;
            if (iss_idx == LAST_IDX) issuing <= 1'b0;
            else                     iss_idx <= iss_idx + 1'b1;
        end else begin
            chk_vld <= 1'b0;
        end
    end

    // Drive the table port and flag the final index.
    always_comb begin
        rd_en    = issuing;
        rd_addr  = iss_idx;
        chk_last = (chk_idx == LAST_IDX);
    end
endmodule

// File: rtl/lut_search_engine.sv
// Lookup table search engine top.
// Takes a command while idle, scans the table in ascending order through
// the read sequencer, and reports the first qualifying index. For an insert
// it reports the match, else the first free index, else the first evictable
// index. Assumes read data arrives one cycle after a read and that the table
// is stable during a scan.
module lut_search_engine
    import lse_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [MAC_W-1:0]   cmd_mac,
    input  logic [VID_W-1:0]   cmd_vid,
    output logic               busy,
    output logic               done,
    output logic               found,
    output logic [IDX_W-1:0]   index,
    output logic               tbl_rd_en,
    output logic [IDX_W-1:0]   tbl_rd_addr,
    input  logic [ENTRY_W-1:0] tbl_rd_data
);
    logic             accept;
    logic [2:0]       q_op;
    logic [MAC_W-1:0] q_mac;
    logic [VID_W-1:0] q_vid;
    logic             chk_vld, chk_last;
    logic [IDX_W-1:0] chk_idx;
    lse_class_t       cls;
    logic             hit, finish;
    logic             have_free, have_evict;
    logic [IDX_W-1:0] free_idx, evict_idx;
    logic             nxt_have_free, nxt_have_evict;
    logic [IDX_W-1:0] nxt_free_idx, nxt_evict_idx;
    logic             res_found;
    logic [IDX_W-1:0] res_idx;

    assign accept = cmd_valid && !busy;

    lse_read_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .stop(finish),
        .rd_en(tbl_rd_en), .rd_addr(tbl_rd_addr),
        .chk_vld(chk_vld), .chk_idx(chk_idx), .chk_last(chk_last)
    );

    lse_entry_classify u_cls (
        .entry(tbl_rd_data), .key_mac(q_mac), .key_vid(q_vid), .cls(cls)
    );

    // Select the criterion for this command and form the insert fallbacks.
    always_comb begin
        case (q_op)
            OP_ADDR, OP_INSERT: hit = cls.addr_hit;
            OP_VLAN:            hit = cls.vlan_hit;
            OP_FREE:            hit = cls.is_free;
            OP_AGE:             hit = cls.evictable;
            default:            hit = 1'b0;
        endcase
        finish         = chk_vld && (hit || chk_last);
        nxt_have_free  = have_free || cls.is_free;
        nxt_free_idx   = have_free ? free_idx : chk_idx;
        nxt_have_evict = have_evict || cls.evictable;
        nxt_evict_idx  = have_evict ? evict_idx : chk_idx;

        res_found = 1'b0;
        res_idx   = '0;
        if (hit) begin
            res_found = 1'b1;
            res_idx   = chk_idx;
        end else if (q_op == OP_INSERT && nxt_have_free) begin
            res_found = 1'b1;
            res_idx   = nxt_free_idx;
        end else if (q_op == OP_INSERT && nxt_have_evict) begin
            res_found = 1'b1;
            res_idx   = nxt_evict_idx;
        end
    end

    // Take a command while idle and hold its key until the scan ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            q_op  <= '0;
            q_mac <= '0;
            q_vid <= '0;
        end else if (accept) begin
            busy  <= 1'b1;
            q_op  <= cmd_op;
            q_mac <= cmd_mac;
            q_vid <= cmd_vid;
        end else if (finish) begin
            busy  <= 1'b0;
        end
    end

    // Remember the first free and first evictable index seen in this scan.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            have_free  <= 1'b0;
            have_evict <= 1'b0;
            free_idx   <= '0;
            evict_idx  <= '0;
        end else if (chk_vld) begin
            have_free  <= nxt_have_free;
            have_evict <= nxt_have_evict;
            free_idx   <= nxt_free_idx;
            evict_idx  <= nxt_evict_idx;
        end
    end

    // Register the result and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            found <= 1'b0;
            index <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                found <= res_found;
                index <= res_idx;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && !tbl_rd_en) else $error("reset state");   // R1
    AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |-> busy) else $error("read while idle");                      // R3
    AST_SCAN_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> tbl_rd_en && tbl_rd_addr == '0) else $error("scan start"); // R3
    AST_READ_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en && $past(tbl_rd_en) |-> tbl_rd_addr == IDX_W'($past(tbl_rd_addr) + 1'b1))
        else $error("read order");                                               // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done width");                              // R4
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done) else $error("busy fall without done");            // R4
    AST_BUSY_HOLDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(q_op) && $stable(q_vid)) else $error("key changed"); // R2
    AST_MISS_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && !found |-> index == '0) else $error("miss index");              // R10
endmodule

// File: tb/tb_lut_search_engine.sv
// Self-checking bench: a behavioural model predicts the result and timing
// of each command, and the outputs are compared on every clock.
module tb_lut_search_engine;
    localparam int DEPTH = 16;
    localparam int IDX_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [47:0]       cmd_mac = '0;
    logic [11:0]       cmd_vid = '0;
    logic              busy, done, found, tbl_rd_en;
    logic [IDX_W-1:0]  index, tbl_rd_addr;
    logic [63:0]       tbl_rd_data = '0;
    logic [63:0]       mem [DEPTH];
    int                checks = 0;
    int                errors = 0;

    always #5 clk = ~clk;

    lut_search_engine #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mac(cmd_mac), .cmd_vid(cmd_vid), .busy(busy), .done(done),
        .found(found), .index(index), .tbl_rd_en(tbl_rd_en),
        .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data)
    );

    always_ff @(posedge clk) if (tbl_rd_en) tbl_rd_data <= mem[tbl_rd_addr];

    localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
    localparam logic [47:0] MAC_M = 48'h01_00_5e_00_00_01;
    localparam logic [47:0] MAC_C = 48'h02_aa_bb_cc_dd_ee;

    function automatic logic [63:0] ent(input logic [1:0] uc, input logic [1:0] t,
                                        input logic [11:0] v, input logic [47:0] m);
        return {uc, t, v, m};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural model of one command: result and completion cycle.
    task automatic model(input int op, input logic [47:0] m, input logic [11:0] v,
                         output bit f, output int ix, output int lat);
        int mi = -1, fi = -1, ai = -1;
        f = 0; ix = 0; lat = DEPTH + 1;
        for (int i = 0; i < DEPTH; i++) begin
            logic [1:0] t = mem[i][61:60];
            logic [1:0] uc = mem[i][63:62];
            bit am = (t == 1 || t == 3) && mem[i][59:48] == v && mem[i][47:0] == m;
            bit vm = (t == 2) && mem[i][59:48] == v;
            bit fr = (t == 0);
            bit ag = (t == 1 || t == 3) && !mem[i][40] && uc != 0 && uc != 2;
            bit h = (op == 0 || op == 4) ? am : (op == 1) ? vm : (op == 2) ? fr :
                    (op == 3) ? ag : 1'b0;
            if (fr && fi < 0) fi = i;
            if (ag && ai < 0) ai = i;
            if (h && mi < 0) mi = i;
        end
        if (mi >= 0) begin f = 1; ix = mi; lat = mi + 2; end
        else if (op == 4 && fi >= 0) begin f = 1; ix = fi; end
        else if (op == 4 && ai >= 0) begin f = 1; ix = ai; end
    endtask

    // Issue one command and compare the outputs on every cycle until after done.
    task automatic run(input int op, input logic [47:0] m, input logic [11:0] v,
                       input string req, input bit poke);
        bit ef; int eix, lat, rdmax;
        model(op, m, v, ef, eix, lat);
        rdmax = (lat - 1 < DEPTH - 1) ? lat - 1 : DEPTH - 1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_mac = m; cmd_vid = v;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 0; c <= lat + 2; c++) begin
            if (c > 0) @(negedge clk);
            if (poke && c == 1) begin
                cmd_valid = 1'b1; cmd_op = 3'd2; cmd_mac = MAC_C; cmd_vid = 12'd9;
            end
            if (poke && c == 2) cmd_valid = 1'b0;
            check(done == (c == lat) && busy == (c < lat), "R4", "done/busy timing",
                  {30'd0, done, busy}, {30'd0, c == lat, c < lat});
            check(tbl_rd_en == (c <= rdmax) && (!tbl_rd_en || tbl_rd_addr == IDX_W'(c)),
                  "R3", "read enable/address", int'(tbl_rd_addr), c);
            if (c == lat) begin
                check(found == ef, req, "found", found, ef);
                check(!ef || index == IDX_W'(eix), req, "index", index, eix);
            end
            if (poke && c > lat)
                check(!busy && !done, "R2", "ignored command started", busy, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !found && !tbl_rd_en && index == '0, "R1",
              "reset outputs", {busy, done, found, tbl_rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !tbl_rd_en, "R1", "idle after reset", busy, 0);

        // Empty table.
        run(2, MAC_A, 12'd5, "R7", 0);
        run(0, MAC_A, 12'd5, "R10", 0);
        run(4, MAC_A, 12'd5, "R9", 0);

        // Populated table: unmarked slots hold VLAN entries.
        for (int i = 0; i < DEPTH; i++) mem[i] = ent(2'd0, 2'd2, 12'(100 + i), '0);
        mem[1] = ent(2'd0, 2'd2, 12'd5, MAC_A);
        mem[2] = ent(2'd1, 2'd1, 12'd5, MAC_M);
        mem[3] = ent(2'd0, 2'd1, 12'd5, MAC_A);
        mem[4] = ent(2'd2, 2'd1, 12'd5, MAC_C);
        mem[5] = ent(2'd3, 2'd3, 12'd7, MAC_A);
        run(0, MAC_A, 12'd5, "R5", 0);
        run(0, MAC_A, 12'd7, "R5", 0);
        run(0, MAC_A, 12'd6, "R5", 0);
        run(0, MAC_A ^ 48'h1, 12'd5, "R5", 0);
        run(1, 48'h0, 12'd5, "R6", 0);
        run(1, 48'h0, 12'd7, "R6", 0);
        run(2, 48'h0, 12'd0, "R7", 0);
        run(3, 48'h0, 12'd0, "R8", 0);
        run(4, MAC_A, 12'd7, "R9", 0);
        run(4, MAC_C, 12'd1, "R9", 0);
        mem[12] = '0;
        run(4, MAC_C, 12'd1, "R9", 0);
        run(4, MAC_A, 12'd5, "R9", 0);
        mem[12] = ent(2'd0, 2'd2, 12'd300, '0);
        mem[5]  = ent(2'd0, 2'd2, 12'd301, '0);
        run(4, MAC_C, 12'd1, "R10", 0);
        run(3, 48'h0, 12'd0, "R8", 0);
        mem[15] = '0;
        run(2, 48'h0, 12'd0, "R7", 0);
        run(6, MAC_A, 12'd5, "R2", 0);
        run(0, MAC_C, 12'd40, "R2", 1);
        @(negedge clk);
        check(found == 1'b0 && index == '0, "R10", "result held after done", found, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule